// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block moves data words from a write clock domain to an unrelated read clock domain through an inferred memory. Each side keeps its own binary pointer. The pointer is also held in Gray code and passed to the other side through a two-stage synchronizer. From its own pointer and the synchronized copy of the other pointer, each side works out a fill level, and from that level it registers its own status flags. The write side owns `full` and `afull`. The read side owns `empty` and `aempty`.

The almost thresholds are absolute fill levels given at run time. The full level is a build parameter. The thresholds are meant to satisfy 0 < almost-empty < almost-full ≤ full. A threshold that lands on the empty or full value behaves as that flag. A threshold outside its legal range is pulled back to the nearest legal meaning. Parameters select two options:
- whether read data is taken straight from the memory read register or passes through one more output register;
- whether the internal reset is applied asynchronously or synchronously. Release is synchronous to each clock in both cases.

Top module: `dcfifo_flags`

## Requirements
- R1: While reset is active and right after it, `empty`=1, `aempty`=1, `full`=0 and `afull`=0. Both pointers restart at address 0, so the first word written after reset is the first word read.
- R2: Words leave in the order they were accepted, with no loss and no duplication, whatever the relative speed of the two clocks.
- R3: `full` is 1 whenever the write-side fill level is at least FULL_LVL. A write attempted while `full` is 1 is ignored and stores nothing.
- R4: `afull` is 1 whenever the write-side fill level is at least the effective almost-full level. That level is `af_lvl`, except when `af_lvl` is 0 or greater than FULL_LVL; then FULL_LVL is used. `afull` is therefore always 1 when `full` is 1.
- R5: `empty` is 1 whenever the read-side fill level is 0. A read attempted while `empty` is 1 is ignored, and `rd_data` keeps its previous value.
- R6: `aempty` is 1 whenever the read-side fill level is at most the effective almost-empty level. That level is `ae_lvl`, except when `ae_lvl` is FULL_LVL or more; then FULL_LVL−1 is used. An `ae_lvl` of 0 makes `aempty` follow `empty`.
- R7: Each flag is a register in its own clock domain. `full`/`afull` and `empty`/`aempty` may stay set for a few cycles after the other side drains or fills. They never clear early: no write is accepted beyond FULL_LVL stored words, and no read is accepted from a FIFO with no words.
- R8: With RD_MODE = RD_DIRECT, `rd_data` shows the word after the `rd_clk` edge that accepts the read. With RD_MODE = RD_PIPED, it shows the word one `rd_clk` edge later.
- R9: With RST_MODE = RST_ASYNC, a low `rst_n` clears the flags at once, without a clock edge. With RST_MODE = RST_SYNC, the flags change only on clock edges, two to three edges after `rst_n` falls. In both modes release comes two edges after `rst_n` rises.
- R10: Each Gray pointer that crosses domains changes at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| af_lvl | input | LVL_W | Almost-full fill level (write domain) |
| full | output | 1 | Fill level has reached FULL_LVL |
| afull | output | 1 | Fill level has reached the almost-full level |
| rd_en | input | 1 | Read request |
| ae_lvl | input | LVL_W | Almost-empty fill level (read domain) |
| rd_data | output | DATA_W | Word read |
| empty | output | 1 | No word stored (read view) |
| aempty | output | 1 | Fill level at or below the almost-empty level |

## Verification
The assertions assume three things about the inputs:
- `af_lvl` is steady in the write domain and `ae_lvl` is steady in the read domain while traffic flows.
- `rst_n` reaches both domains for at least a few cycles of each clock.
- Requests are simple level enables sampled on the rising edge.

The bench keeps within these limits in four ways:
- It changes the thresholds only while both sides are idle and settled.
- It holds reset across several edges of both clocks.
- It drives every request on the falling edge of its own clock.
- It compares exact flag values only after the opposite side has been idle long enough for its pointer to cross over. While both sides are active, it checks only that no acceptance contradicts the true occupancy.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {RST_SYNC = 1'b0, RST_ASYNC = 1'b1} rst_mode_e;
  typedef enum logic {RD_DIRECT = 1'b0, RD_PIPED = 1'b1} rd_mode_e;
endpackage

// File: rtl/dcf_rst_ctrl.sv
module dcf_rst_ctrl
  import dcf_pkg::*;
#(
  parameter rst_mode_e MODE = RST_ASYNC
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n,
  output logic srst
);
  logic [1:0] stg_q;

  generate
    if (MODE == RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 2'b00;
        else        stg_q <= {stg_q[0], 1'b1};
      end
      assign arst_n = stg_q[1];
      assign srst   = 1'b0;
    end else begin : g_sync
      always_ff @(posedge clk) begin
        stg_q <= {stg_q[0], rst_n};
      end
      assign arst_n = 1'b1;
      assign srst   = ~stg_q[1];
    end
  endgenerate
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int LVL_W    = 5,
  parameter int FULL_LVL = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] af_lvl,
  input  logic [LVL_W-1:0] rgray_a,
  output logic [LVL_W-2:0] waddr,
  output logic [LVL_W-1:0] wgray,
  output logic [LVL_W-1:0] lvl,
  output logic             wr_ok,
  output logic             full,
  output logic             afull
);
  localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL_LVL);

  logic [LVL_W-1:0] rs1_q, rs2_q, rbin_s;
  logic [LVL_W-1:0] wbin_q, wbin_n, wgray_q, wgray_n, lvl_n, af_eff;
  logic             full_q, full_n, afull_q, afull_n;

  always_comb begin
    for (int i = 0; i < LVL_W; i++) rbin_s[i] = ^(rs2_q >> i);
    af_eff  = ((af_lvl == '0) || (af_lvl > FULL_V)) ? FULL_V : af_lvl;
    wr_ok   = wr_en & ~full_q;
    wbin_n  = wbin_q + LVL_W'(wr_ok);
    wgray_n = wbin_n ^ (wbin_n >> 1);
    lvl_n   = wbin_n - rbin_s;
    full_n  = (lvl_n >= FULL_V);
    afull_n = (lvl_n >= af_eff);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q <= '0; rs2_q <= '0; wbin_q <= '0; wgray_q <= '0;
      full_q <= 1'b0; afull_q <= 1'b0;
    end else if (srst) begin
      rs1_q <= '0; rs2_q <= '0; wbin_q <= '0; wgray_q <= '0;
      full_q <= 1'b0; afull_q <= 1'b0;
    end else begin
      rs1_q   <= rgray_a;
      rs2_q   <= rs1_q;
      if (wr_ok) begin
        wbin_q  <= wbin_n;
        wgray_q <= wgray_n;
      end
      full_q  <= full_n;
      afull_q <= afull_n;
    end
  end

  assign waddr = wbin_q[LVL_W-2:0];
  assign wgray = wgray_q;
  assign lvl   = wbin_q - rbin_s;
  assign full  = full_q;
  assign afull = afull_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int LVL_W    = 5,
  parameter int FULL_LVL = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst,
  input  logic             rd_en,
  input  logic [LVL_W-1:0] ae_lvl,
  input  logic [LVL_W-1:0] wgray_a,
  output logic [LVL_W-2:0] raddr,
  output logic [LVL_W-1:0] rgray,
  output logic             rd_ok,
  output logic             empty,
  output logic             aempty
);
  localparam logic [LVL_W-1:0] FULL_V = LVL_W'(FULL_LVL);

  logic [LVL_W-1:0] ws1_q, ws2_q, wbin_s;
  logic [LVL_W-1:0] rbin_q, rbin_n, rgray_q, rgray_n, lvl_n, ae_eff;
  logic             empty_q, empty_n, aempty_q, aempty_n;

  always_comb begin
    for (int i = 0; i < LVL_W; i++) wbin_s[i] = ^(ws2_q >> i);
    ae_eff   = (ae_lvl >= FULL_V) ? (FULL_V - LVL_W'(1)) : ae_lvl;
    rd_ok    = rd_en & ~empty_q;
    rbin_n   = rbin_q + LVL_W'(rd_ok);
    rgray_n  = rbin_n ^ (rbin_n >> 1);
    lvl_n    = wbin_s - rbin_n;
    empty_n  = (lvl_n == '0);
    aempty_n = (lvl_n <= ae_eff);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ws1_q <= '0; ws2_q <= '0; rbin_q <= '0; rgray_q <= '0;
      empty_q <= 1'b1; aempty_q <= 1'b1;
    end else if (srst) begin
      ws1_q <= '0; ws2_q <= '0; rbin_q <= '0; rgray_q <= '0;
      empty_q <= 1'b1; aempty_q <= 1'b1;
    end else begin
      ws1_q <= wgray_a;
      ws2_q <= ws1_q;
      if (rd_ok) begin
        rbin_q  <= rbin_n;
        rgray_q <= rgray_n;
      end
      empty_q  <= empty_n;
      aempty_q <= aempty_n;
    end
  end

  assign raddr  = rbin_q[LVL_W-2:0];
  assign rgray  = rgray_q;
  assign empty  = empty_q;
  assign aempty = aempty_q;
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram
  import dcf_pkg::*;
#(
  parameter int       DATA_W  = 8,
  parameter int       AW      = 4,
  parameter rd_mode_e RD_MODE = RD_DIRECT
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              arst_n,
  input  logic              srst,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q1;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) q1 <= mem[raddr];
  end

  generate
    if (RD_MODE == RD_PIPED) begin : g_piped
      logic              vld_q;
      logic [DATA_W-1:0] q2;
      always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n)   vld_q <= 1'b0;
        else if (srst) vld_q <= 1'b0;
        else           vld_q <= re;
      end
      always_ff @(posedge rclk) begin
        if (vld_q) q2 <= q1;
      end
      assign rdata = q2;
    end else begin : g_direct
      assign rdata = q1;
    end
  endgenerate
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcf_pkg::*;
#(
  parameter int        DATA_W   = 8,
  parameter int        DEPTH    = 16,
  parameter int        FULL_LVL = DEPTH,
  parameter rd_mode_e  RD_MODE  = RD_DIRECT,
  parameter rst_mode_e RST_MODE = RST_ASYNC,
  localparam int       AW       = $clog2(DEPTH),
  localparam int       LVL_W    = AW + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  af_lvl,
  output logic              full,
  output logic              afull,
  input  logic              rd_en,
  input  logic [LVL_W-1:0]  ae_lvl,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              aempty
);
  logic             w_arst_n, w_srst, r_arst_n, r_srst;
  logic [AW-1:0]    waddr, raddr;
  logic [LVL_W-1:0] wgray, rgray, wlvl;
  logic             wr_ok, rd_ok;

  dcf_rst_ctrl #(.MODE(RST_MODE)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .arst_n(w_arst_n), .srst(w_srst));

  dcf_rst_ctrl #(.MODE(RST_MODE)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .arst_n(r_arst_n), .srst(r_srst));

  dcf_wr_ctl #(.LVL_W(LVL_W), .FULL_LVL(FULL_LVL)) u_wr (
    .clk(wr_clk), .arst_n(w_arst_n), .srst(w_srst), .wr_en(wr_en),
    .af_lvl(af_lvl), .rgray_a(rgray), .waddr(waddr), .wgray(wgray),
    .lvl(wlvl), .wr_ok(wr_ok), .full(full), .afull(afull));

  dcf_rd_ctl #(.LVL_W(LVL_W), .FULL_LVL(FULL_LVL)) u_rd (
    .clk(rd_clk), .arst_n(r_arst_n), .srst(r_srst), .rd_en(rd_en),
    .ae_lvl(ae_lvl), .wgray_a(wgray), .raddr(raddr), .rgray(rgray),
    .rd_ok(rd_ok), .empty(empty), .aempty(aempty));

  dcf_ram #(.DATA_W(DATA_W), .AW(AW), .RD_MODE(RD_MODE)) u_ram (
    .wclk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .arst_n(r_arst_n), .srst(r_srst), .re(rd_ok),
    .raddr(raddr), .rdata(rd_data));
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int LVL_W    = 5,
  parameter int FULL_LVL = 16
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             w_arst_n,
  input logic             w_srst,
  input logic             r_arst_n,
  input logic             r_srst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             full,
  input logic             afull,
  input logic             empty,
  input logic             aempty,
  input logic [LVL_W-1:0] wgray,
  input logic [LVL_W-1:0] rgray,
  input logic [LVL_W-1:0] wlvl
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!w_arst_n || w_srst)
    wlvl <= LVL_W'(FULL_LVL)); // R3
  AST_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (!w_arst_n || w_srst)
    (full && wr_en) |=> $stable(wgray)); // R3
  AST_AFULL_WITH_FULL: assert property (@(posedge wr_clk) disable iff (!w_arst_n || w_srst)
    full |-> afull); // R4
  AST_EMPTY_BLOCKS: assert property (@(posedge rd_clk) disable iff (!r_arst_n || r_srst)
    (empty && rd_en) |=> $stable(rgray)); // R5
  AST_AEMPTY_WITH_EMPTY: assert property (@(posedge rd_clk) disable iff (!r_arst_n || r_srst)
    empty |-> aempty); // R6
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!w_arst_n || w_srst)
    $countones(wgray ^ $past(wgray)) <= 1); // R10
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!r_arst_n || r_srst)
    $countones(rgray ^ $past(rgray)) <= 1); // R10
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.LVL_W(LVL_W), .FULL_LVL(FULL_LVL)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_arst_n(w_arst_n), .w_srst(w_srst),
  .r_arst_n(r_arst_n), .r_srst(r_srst), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .afull(afull), .empty(empty), .aempty(aempty),
  .wgray(wgray), .rgray(rgray), .wlvl(wlvl));

// File: tb/sim_dcfifo_flags.sv
`timescale 1ns/1ps
module sim_dcfifo_flags;
  import dcf_pkg::*;
  localparam int DW = 8, DEPTH = 16, FULL = 16, LW = 5;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] af_lvl = 5'd12, ae_lvl = 5'd3;
  logic full0, afull0, empty0, aempty0, full1, afull1, empty1, aempty1;
  logic [DW-1:0] rd0, rd1;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_flags #(.DATA_W(DW), .DEPTH(DEPTH), .FULL_LVL(FULL),
                 .RD_MODE(RD_DIRECT), .RST_MODE(RST_ASYNC)) u0 (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .af_lvl(af_lvl), .full(full0), .afull(afull0), .rd_en(rd_en), .ae_lvl(ae_lvl),
    .rd_data(rd0), .empty(empty0), .aempty(aempty0));

  dcfifo_flags #(.DATA_W(DW), .DEPTH(DEPTH), .FULL_LVL(FULL),
                 .RD_MODE(RD_PIPED), .RST_MODE(RST_SYNC)) u1 (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .af_lvl(af_lvl), .full(full1), .afull(afull1), .rd_en(rd_en), .ae_lvl(ae_lvl),
    .rd_data(rd1), .empty(empty1), .aempty(aempty1));

  int n_chk = 0, n_bad = 0, wcyc = 0;
  logic [DW-1:0] mq[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic void check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic bit coin();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    mq.delete();
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    acc = !full0;
    if (acc) check(mq.size() < FULL, "R7 write accepted only below capacity", mq.size(), FULL - 1);
    wr_en = 1'b1; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
    if (acc) mq.push_back(d);
  endtask

  task automatic rd_word(output bit acc);
    logic [DW-1:0] exp;
    @(negedge rclk);
    acc = !empty0;
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (acc) begin
      check(mq.size() > 0, "R7 read accepted only when data stored", mq.size(), 1);
      exp = (mq.size() > 0) ? mq.pop_front() : '0;
      check(rd0 == exp, "R2/R8 direct read data", rd0, exp);
      @(negedge rclk);
      check(rd1 == exp, "R8 piped read data one edge later", rd1, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge wclk);
    check(empty0 == 1 && empty1 == 1, "R1 empty high in reset", empty0, 1);
    check(aempty0 == 1 && aempty1 == 1, "R1 aempty high in reset", aempty0, 1);
    check(full0 == 0 && full1 == 0, "R1 full low in reset", full0, 0);
    check(afull0 == 0 && afull1 == 0, "R1 afull low in reset", afull0, 0);
    do_reset();
    check(empty0 == 1 && aempty0 == 1 && full0 == 0 && afull0 == 0,
          "R1 flags after release", {empty0, aempty0, full0, afull0}, 4'b1100);
  endtask

  task automatic t_fill_drain();
    bit acc;
    af_lvl = 5'd12; ae_lvl = 5'd3;
    do_reset();
    for (int k = 1; k <= FULL; k++) begin
      wr_word(DW'(8'h10 + k), acc);
      check(full0 == (k >= FULL), "R3 full vs level", full0, int'(k >= FULL));
      check(afull0 == (k >= 12), "R4 afull vs level", afull0, int'(k >= 12));
    end
    for (int k = 0; k < 3; k++) begin
      wr_word(8'hEE, acc);
      check(acc == 0, "R3 write while full is refused", acc, 0);
      check(full0 == 1, "R3 full holds", full0, 1);
    end
    settle();
    check(empty0 == 0 && aempty0 == 0, "R5/R6 read side sees full FIFO", {empty0, aempty0}, 0);
    for (int j = 1; j <= FULL; j++) begin
      rd_word(acc);
      check(acc == 1, "R5 read accepted while data stored", acc, 1);
      check(empty0 == (FULL - j == 0), "R5 empty vs level", empty0, int'(FULL - j == 0));
      check(aempty0 == (FULL - j <= 3), "R6 aempty vs level", aempty0, int'(FULL - j <= 3));
    end
    settle();
    check(full0 == 0 && afull0 == 0, "R7 write flags clear after drain", {full0, afull0}, 0);
  endtask

  task automatic t_empty_read();
    bit acc;
    logic [DW-1:0] hold0;
    hold0 = rd0;
    for (int k = 0; k < 3; k++) begin
      rd_word(acc);
      check(acc == 0, "R5 read on empty refused", acc, 0);
      check(rd0 == hold0, "R5 rd_data unchanged on empty read", rd0, hold0);
    end
    wr_word(8'h5A, acc);
    settle();
    rd_word(acc);
    check(acc == 1, "R5 pointers intact after empty reads", acc, 1);
  endtask

  task automatic t_fallback();
    bit acc;
    af_lvl = 5'd0; ae_lvl = 5'd31;
    do_reset();
    for (int k = 1; k < FULL; k++) wr_word(DW'(k), acc);
    check(afull0 == 0, "R4 af_lvl 0 falls back to full level", afull0, 0);
    settle();
    check(aempty0 == 1, "R6 ae_lvl clamps to FULL-1 (15 stored)", aempty0, 1);
    wr_word(8'h99, acc);
    check(afull0 == 1 && full0 == 1, "R4 afull with full at fallback", {afull0, full0}, 3);
    settle();
    check(aempty0 == 0, "R6 aempty clears at FULL stored", aempty0, 1'b0);
    af_lvl = 5'd20; ae_lvl = 5'd0;
    repeat (4) @(negedge wclk);
    check(afull0 == 1, "R4 af_lvl above FULL uses FULL", afull0, 1);
    for (int j = 0; j < FULL; j++) rd_word(acc);
    check(empty0 == 1 && aempty0 == 1, "R6 ae_lvl 0 follows empty", {empty0, aempty0}, 3);
    settle();
  endtask

  task automatic t_stream();
    int got = 0;
    af_lvl = 5'd10; ae_lvl = 5'd4;
    do_reset();
    fork
      begin
        bit acc;
        int sent = 0;
        while (sent < 150) begin
          wr_word(DW'(sent * 7 + 3), acc);
          if (acc) sent++;
          if (coin()) @(negedge wclk);
        end
      end
      begin
        bit acc;
        while (got < 150) begin
          rd_word(acc);
          if (acc) got++;
          if (coin()) repeat (2) @(negedge rclk);
        end
      end
    join
    check(got == 150, "R2 all streamed words received", got, 150);
    settle();
    check(empty0 == 1 && mq.size() == 0, "R2 FIFO drained after stream", empty0, 1);
  endtask

  task automatic t_midreset();
    bit acc;
    af_lvl = 5'd4; ae_lvl = 5'd2;
    for (int k = 0; k < 5; k++) wr_word(DW'(8'hA0 + k), acc);
    check(afull0 == 1 && afull1 == 1, "R4 afull set before reset", {afull0, afull1}, 3);
    @(negedge wclk);
    rst_n = 1'b0;
    #1;
    check(afull0 == 0, "R9 async reset clears afull without an edge", afull0, 0);
    check(afull1 == 1, "R9 sync reset waits for clock edges", afull1, 1);
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
    check(afull1 == 0 && empty1 == 1, "R9 sync reset applied after edges", {afull1, empty1}, 1);
    rst_n = 1'b1;
    mq.delete();
    settle();
    check(empty0 == 1 && empty1 == 1, "R1 empty after mid-run reset", {empty0, empty1}, 3);
    wr_word(8'h77, acc);
    settle();
    rd_word(acc);
    check(acc == 1, "R1 first word after reset read back", acc, 1);
  endtask

  initial begin
    forever begin
      @(posedge wclk);
      wcyc++;
      if (wcyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wcyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_fill_drain();
    t_empty_read();
    t_fallback();
    t_stream();
    t_midreset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule